// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table stored in untranslated physical memory. The pipeline hands it a 32-bit virtual address together with the current table root. The walker reads the first-level entry, then the second-level entry it points to, and either refills the translation buffer or reports a page fault.

The virtual address is split 10/10/12. The upper ten bits select a first-level entry and the middle ten bits select a second-level entry. The low twelve bits are the offset inside a 4 KB page. Entries are four bytes wide.

Memory is reached through a bare request/response port. A request is a one-cycle strobe with an address. The reply is a one-cycle strobe with a data word and may arrive any number of cycles later. A walk does not retry. As soon as it meets an entry whose resident bit is clear, it stops and reports a fault against the original virtual address.

Top module: `pt_walker`

## Requirements
- R1: After reset, `ready` is 1 and `mem_req_valid`, `refill_valid` and `fault_valid` are all 0.
- R2: A miss is taken only in a cycle where `ready` is 1. A `miss_valid` that arrives during a walk has no effect on that walk's requests or results.
- R3: In the cycle after a miss is accepted, `mem_req_valid` is 1 for exactly one cycle with `mem_req_addr` = `root_base` + 4 × vaddr[31:22], using 32-bit wrap-around.
- R4: Entry layout: bit 0 is the resident flag, bits 31:12 are the physical page number and bits 11:1 are status. In the cycle after a resident first-level reply, a one-cycle request goes out to {entry[31:12], vaddr[21:12], 2'b00}.
- R5: In the cycle after a first-level reply with bit 0 clear, `fault_valid` is 1 for one cycle with `fault_level` = 0 and `fault_vaddr` = the missed address. No second request is issued.
- R6: In the cycle after a second-level reply with bit 0 clear, `fault_valid` is 1 for one cycle with `fault_level` = 1 and `fault_vaddr` = the missed address.
- R7: In the cycle after a resident second-level reply, `refill_valid` is 1 for one cycle with `refill_vpn` = vaddr[31:12], `refill_ppn` = entry[31:12] and `refill_status` = entry[11:1].
- R8: The walker waits any number of cycles for a reply. A `mem_rsp_valid` that arrives while no read is outstanding is ignored, and no request is issued while waiting.
- R9: `refill_valid` and `fault_valid` are never 1 together. `ready` is 1 in the cycle after either of them, so a new miss can be accepted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A translation miss is presented |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_base | input | 32 | Physical address of the first-level table |
| ready | output | 1 | Walker is idle and can accept a miss |
| mem_req_valid | output | 1 | One-cycle read request strobe |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| refill_valid | output | 1 | One-cycle translation refill strobe |
| refill_vpn | output | 20 | Virtual page number being refilled |
| refill_ppn | output | 20 | Physical page number of the mapping |
| refill_status | output | 11 | Status bits of the leaf entry |
| fault_valid | output | 1 | One-cycle page fault strobe |
| fault_vaddr | output | 32 | Virtual address that faulted |
| fault_level | output | 1 | 0: first-level entry absent, 1: second-level entry absent |

## Verification
The hardest case to create from the ports is a memory reply that arrives while no read is outstanding. This can happen in the cycle the request itself is presented, or while a second miss competes with a walk in progress. A correct walker must let such strobes pass with no effect. The bench's memory model can inject a non-resident reply in the request cycle and hold a different `miss_valid` throughout the wait. An erroneous capture of either one then shows up as a wrong address, a spurious fault or a wrong refill page. Replies are also delayed by several cycles, and a reset arrives in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W    = 32;
    localparam int OFFS_W    = 12;
    localparam int IDX_W     = 10;
    localparam int ENTRY_B   = 4;
    localparam int ENTRY_SH  = $clog2(ENTRY_B);
    localparam int PN_W      = ADDR_W - OFFS_W;
    localparam int STAT_W    = OFFS_W - 1;
    localparam int IDX1_LSB  = OFFS_W + IDX_W;
    localparam int IDX2_LSB  = OFFS_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [PN_W-1:0]   ppn;
        logic [STAT_W-1:0] status;
        logic              resident;
    } table_entry_t;

    function automatic table_entry_t unpack_entry(input logic [ADDR_W-1:0] word);
        table_entry_t e;
        e.ppn      = word[ADDR_W-1:OFFS_W];
        e.status   = word[OFFS_W-1:1];
        e.resident = word[0];
        return e;
    endfunction

    function automatic logic [ADDR_W-1:0] first_entry_addr(
        input logic [ADDR_W-1:0] root,
        input logic [ADDR_W-1:0] va
    );
        logic [ADDR_W-1:0] scaled;
        scaled = '0;
        scaled[ENTRY_SH +: IDX_W] = va[IDX1_LSB +: IDX_W];
        return root + scaled;
    endfunction

    function automatic logic [ADDR_W-1:0] second_entry_addr(
        input logic [PN_W-1:0]   table_pn,
        input logic [ADDR_W-1:0] va
    );
        logic [ADDR_W-1:0] a;
        a = '0;
        a[ADDR_W-1:OFFS_W]        = table_pn;
        a[ENTRY_SH +: IDX_W]      = va[IDX2_LSB +: IDX_W];
        return a;
    endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        miss_valid,
    input  logic        rsp_valid,
    input  logic        rsp_resident,
    output walk_state_e state,
    output logic        take_miss,
    output logic        take_l1,
    output logic        take_l2
);

    walk_state_e nxt;

    assign take_miss = (state == ST_IDLE) && miss_valid;
    assign take_l1   = (state == ST_L1_WAIT) && rsp_valid;
    assign take_l2   = (state == ST_L2_WAIT) && rsp_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (miss_valid) nxt = ST_L1_REQ;
            ST_L1_REQ:  nxt = ST_L1_WAIT;
            ST_L1_WAIT: if (rsp_valid) nxt = rsp_resident ? ST_L2_REQ : ST_FAULT;
            ST_L2_REQ:  nxt = ST_L2_WAIT;
            ST_L2_WAIT: if (rsp_valid) nxt = rsp_resident ? ST_DONE : ST_FAULT;
            ST_DONE:    nxt = ST_IDLE;
            ST_FAULT:   nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  walk_state_e       state,
    input  logic              take_miss,
    input  logic              take_l1,
    input  logic [ADDR_W-1:0] miss_vaddr,
    input  logic [ADDR_W-1:0] root_base,
    input  logic [PN_W-1:0]   rsp_ppn,
    output logic [ADDR_W-1:0] walk_va,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr
);

    logic [ADDR_W-1:0] root_q;
    logic [PN_W-1:0]   table_pn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            walk_va    <= '0;
            root_q     <= '0;
            table_pn_q <= '0;
        end else begin
            if (take_miss) begin
                walk_va <= miss_vaddr;
                root_q  <= root_base;
            end
            if (take_l1) table_pn_q <= rsp_ppn;
        end
    end

    assign req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);

    always_comb begin
        if (state == ST_L2_REQ) req_addr = second_entry_addr(table_pn_q, walk_va);
        else                    req_addr = first_entry_addr(root_q, walk_va);
    end

endmodule

// File: rtl/ptw_result.sv
module ptw_result
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  walk_state_e       state,
    input  logic              take_l2,
    input  table_entry_t      rsp_entry,
    input  logic [ADDR_W-1:0] walk_va,
    output logic              refill_valid,
    output logic [PN_W-1:0]   refill_vpn,
    output logic [PN_W-1:0]   refill_ppn,
    output logic [STAT_W-1:0] refill_status,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic              fault_level
);

    table_entry_t leaf_q;
    logic         level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            leaf_q  <= '0;
            level_q <= 1'b0;
        end else begin
            if (take_l2) leaf_q <= rsp_entry;
            if (state == ST_L1_WAIT) level_q <= 1'b0;
            else if (state == ST_L2_WAIT) level_q <= 1'b1;
        end
    end

    assign refill_valid  = (state == ST_DONE);
    assign refill_vpn    = walk_va[ADDR_W-1:OFFS_W];
    assign refill_ppn    = leaf_q.ppn;
    assign refill_status = leaf_q.status;
    assign fault_valid   = (state == ST_FAULT);
    assign fault_vaddr   = walk_va;
    assign fault_level   = level_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_vaddr,
    input  logic [ADDR_W-1:0] root_base,
    output logic              ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              refill_valid,
    output logic [PN_W-1:0]   refill_vpn,
    output logic [PN_W-1:0]   refill_ppn,
    output logic [STAT_W-1:0] refill_status,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic              fault_level
);

    walk_state_e       state;
    logic              take_miss, take_l1, take_l2;
    table_entry_t      rsp_entry;
    logic [ADDR_W-1:0] walk_va;

    assign rsp_entry = unpack_entry(mem_rsp_data);
    assign ready     = (state == ST_IDLE);

    ptw_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .miss_valid   (miss_valid),
        .rsp_valid    (mem_rsp_valid),
        .rsp_resident (rsp_entry.resident),
        .state        (state),
        .take_miss    (take_miss),
        .take_l1      (take_l1),
        .take_l2      (take_l2)
    );

    ptw_addr u_addr (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .take_miss  (take_miss),
        .take_l1    (take_l1),
        .miss_vaddr (miss_vaddr),
        .root_base  (root_base),
        .rsp_ppn    (rsp_entry.ppn),
        .walk_va    (walk_va),
        .req_valid  (mem_req_valid),
        .req_addr   (mem_req_addr)
    );

    ptw_result u_result (
        .clk           (clk),
        .rst           (rst),
        .state         (state),
        .take_l2       (take_l2),
        .rsp_entry     (rsp_entry),
        .walk_va       (walk_va),
        .refill_valid  (refill_valid),
        .refill_vpn    (refill_vpn),
        .refill_ppn    (refill_ppn),
        .refill_status (refill_status),
        .fault_valid   (fault_valid),
        .fault_vaddr   (fault_vaddr),
        .fault_level   (fault_level)
    );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        miss_valid,
    input logic [31:0] miss_vaddr,
    input logic [31:0] root_base,
    input logic        ready,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        refill_valid,
    input logic [19:0] refill_vpn,
    input logic        fault_valid,
    input logic [31:0] fault_vaddr
);

    logic [31:0] seen_va;

    always_ff @(posedge clk) begin
        if (rst) seen_va <= '0;
        else if (ready && miss_valid) seen_va <= miss_vaddr;
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!mem_req_valid && !refill_valid && !fault_valid));

    a_r3_first_read: assert property (@(posedge clk) disable iff (rst)
        (ready && miss_valid) |=> (mem_req_valid &&
            mem_req_addr == $past(root_base) + {20'd0, $past(miss_vaddr[31:22]), 2'b00}));

    a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    a_r5_fault_addr: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_vaddr == seen_va));

    a_r7_refill_page: assert property (@(posedge clk) disable iff (rst)
        refill_valid |-> (refill_vpn == seen_va[31:12]));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(refill_valid && fault_valid));

    a_r9_back_to_idle: assert property (@(posedge clk) disable iff (rst)
        (refill_valid || fault_valid) |=> ready);

endmodule

bind pt_walker ptw_checker u_ptw_checker (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_vaddr    (miss_vaddr),
    .root_base     (root_base),
    .ready         (ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .refill_valid  (refill_valid),
    .refill_vpn    (refill_vpn),
    .fault_valid   (fault_valid),
    .fault_vaddr   (fault_vaddr)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic        miss_valid;
    logic [31:0] miss_vaddr;
    logic [31:0] root_base;
    logic        ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [19:0] refill_ppn;
    logic [10:0] refill_status;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic        fault_level;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .root_base(root_base),
        .ready(ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_ppn(refill_ppn), .refill_status(refill_status),
        .fault_valid(fault_valid), .fault_vaddr(fault_vaddr), .fault_level(fault_level)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] root;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [3:0]  lat;
        logic        noise;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_3123, 32'h0001_0000, 32'h0002_0001, 32'hABCD_E0F7, 4'd0, 1'b0},
        '{32'hFFFF_FFFF, 32'h0FFF_F000, 32'h1234_5003, 32'h5555_5FFF, 4'd3, 1'b1},
        '{32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h0000_0001, 4'd1, 1'b0},
        '{32'h1234_5678, 32'h0000_4000, 32'h0007_7001, 32'h9999_9FFE, 4'd2, 1'b1},
        '{32'h8020_1ABC, 32'hFFFF_FFF0, 32'hFFFF_F001, 32'h0000_1001, 4'd5, 1'b0},
        '{32'h003F_F000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 4'd0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_reply(input logic [3:0] lat, input logic noise, input logic [31:0] data);
        for (int k = 0; k < lat; k++) begin
            if (noise) begin
                miss_valid = 1'b1;
                miss_vaddr = 32'hDEAD_B000 + k;
            end
            @(negedge clk);
            check("R8 no request while waiting", {31'd0, mem_req_valid}, 32'd0);
        end
        miss_valid    = noise;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        miss_valid    = 1'b0;
    endtask

    task automatic run_walk(input vec_t v);
        logic [31:0] a1, a2;
        a1 = v.root + {20'd0, v.va[31:22], 2'b00};
        a2 = {v.e1[31:12], v.va[21:12], 2'b00};
        check("R2 ready before miss", {31'd0, ready}, 32'd1);
        miss_valid = 1'b1;
        miss_vaddr = v.va;
        root_base  = v.root;
        @(negedge clk);
        miss_valid = v.noise;
        miss_vaddr = 32'h7777_7000;
        root_base  = 32'h0BAD_0000;
        check("R3 first request strobe", {31'd0, mem_req_valid}, 32'd1);
        check("R3 first request address", mem_req_addr, a1);
        if (v.noise) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'h0000_0000;
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R3 request lasts one cycle", {31'd0, mem_req_valid}, 32'd0);
        check("R8 stray reply ignored", {31'd0, fault_valid}, 32'd0);
        wait_reply(v.lat, v.noise, v.e1);
        if (!v.e1[0]) begin
            check("R5 fault strobe", {31'd0, fault_valid}, 32'd1);
            check("R5 fault level", {31'd0, fault_level}, 32'd0);
            check("R5 fault vaddr", fault_vaddr, v.va);
            check("R5 no second request", {31'd0, mem_req_valid}, 32'd0);
            check("R9 exclusive", {31'd0, refill_valid}, 32'd0);
        end else begin
            check("R4 second request strobe", {31'd0, mem_req_valid}, 32'd1);
            check("R4 second request address", mem_req_addr, a2);
            @(negedge clk);
            wait_reply(v.lat, v.noise, v.e2);
            if (!v.e2[0]) begin
                check("R6 fault strobe", {31'd0, fault_valid}, 32'd1);
                check("R6 fault level", {31'd0, fault_level}, 32'd1);
                check("R6 fault vaddr", fault_vaddr, v.va);
                check("R9 exclusive", {31'd0, refill_valid}, 32'd0);
            end else begin
                check("R7 refill strobe", {31'd0, refill_valid}, 32'd1);
                check("R7 refill vpn", {12'd0, refill_vpn}, {12'd0, v.va[31:12]});
                check("R7 refill ppn", {12'd0, refill_ppn}, {12'd0, v.e2[31:12]});
                check("R7 refill status", {21'd0, refill_status}, {21'd0, v.e2[11:1]});
                check("R9 exclusive", {31'd0, fault_valid}, 32'd0);
            end
        end
        @(negedge clk);
        check("R9 ready after result", {31'd0, ready}, 32'd1);
        check("R7 strobe one cycle", {30'd0, refill_valid, fault_valid}, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; miss_valid = 1'b0; miss_vaddr = '0; root_base = '0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 ready after reset", {31'd0, ready}, 32'd1);
        check("R1 outputs quiet after reset",
              {29'd0, mem_req_valid, refill_valid, fault_valid}, 32'd0);

        for (int i = 0; i < NV; i++) run_walk(VECS[i]);

        // back-to-back: accept a miss in the very cycle ready returns (R9)
        run_walk(VECS[0]);
        run_walk(VECS[2]);

        // reset during a walk returns to idle (R1)
        miss_valid = 1'b1; miss_vaddr = 32'h0040_3123; root_base = 32'h0001_0000;
        @(negedge clk);
        miss_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 ready after mid-walk reset", {31'd0, ready}, 32'd1);
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0002_0001;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R8 reply while idle ignored",
              {29'd0, mem_req_valid, refill_valid, fault_valid}, 32'd0);
        run_walk(VECS[3]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule